// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Channel

This block is one counter channel of a general-purpose timer group. A 16-bit up-counter is shared by four software-selected behaviours: a free-running counter that reloads itself on overflow, a compare mode that toggles a waveform pin on a count match, a pulse-width modulator whose period and duty come from two registers, and a capture mode that snapshots the count when an external trigger rises. The counter advances only on ticks of a selected count clock. That clock is either a power-of-two division of the system clock taken from a free-running prescaler, or the rising edge of an external clock that is first synchronised.

Several channels can share one pair of start and stop strobes, so that every channel armed for group control starts or halts on the same clock edge. Any of the three event kinds (overflow or period wrap, compare match, capture) sets a sticky event flag. Software clears that flag by writing a one, and the flag drives the interrupt request when the interrupt is enabled.

Top module: `tmr_channel`

## Requirements
- R1: After reset every register reads zero, the counter and prescaler are zero, and `waveOut`, `waveEn` and `irq` are low.
- R2: In free-running mode (mode 0) each tick adds one to the count. A tick taken at 0xFFFF loads the reload register instead and sets the event flag. Without a tick the count holds.
- R3: Clock select values 0 to 6 give a tick in every cycle in which the low `sel` bits of the free-running prescaler (cleared by reset, +1 per cycle) are all ones, i.e. one tick per 2^sel cycles. Select 7 gives a tick on each rising edge of `extClk`, detected after a two-flop synchroniser, so the count moves on the third clock edge after the input rises. Ticks occur only while the run bit is set.
- R4: In compare mode (mode 1) a tick taken while the count equals the compare register toggles the waveform level and sets the event flag. Counting and overflow behave as in R2.
- R5: In PWM mode (mode 2) a tick at count = reload−1 (mod 2^16) wraps the count to 0 and sets the event flag. `waveOut` is high exactly while count < duty (the compare register), so duty 0 keeps it low and duty ≥ reload keeps it high.
- R6: In capture mode (mode 3) a rising edge of `capTrig`, seen after a two-flop synchroniser, copies the current count into the capture register and sets the event flag. Trigger edges in other modes have no effect.
- R7: `waveEn` is high only in modes 1 and 2. In modes 0 and 3 `waveOut` is low.
- R8: When the group-enable bit is set, `grpStart` sets the run bit and `grpStop` clears it, with start winning if both are pulsed together. A software write to the control register wins over both. With group-enable clear, both strobes are ignored.
- R9: The event flag is cleared by writing 1 to bit 0 of the status register. A new event in the same cycle wins over the clear. `irq` equals flag AND interrupt-enable.
- R10: A write to the count register loads the counter on that edge and takes priority over a tick.
- R11: Register map (regAddr): 0 control {[7] group enable, [6] interrupt enable, [5] run, [4:2] clock select, [1:0] mode}, 1 reload, 2 compare/duty, 3 count, 4 capture (read only), 5 status {[0] flag}. Other addresses read zero. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| grpStart | input | 1 | Shared group start strobe |
| grpStop | input | 1 | Shared group stop strobe |
| extClk | input | 1 | External count clock (asynchronous) |
| capTrig | input | 1 | Capture trigger (asynchronous) |
| waveOut | output | 1 | Waveform output |
| waveEn | output | 1 | Waveform output drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event landing on the same edge as a software action. Examples are an overflow in the cycle the flag is being cleared, or a tick in the cycle the count is being written. The stimulus preloads the count a few steps below 0xFFFF and then issues the clear or load write exactly as the wrap arrives. A behavioural model tracks the prescaler phase and both synchronisers, so divided and external clocks can be checked cycle by cycle without aligning stimulus to hidden phases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CAPT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd5;

  localparam int CTRL_W     = 8;
  localparam int BIT_RUN    = 5;
  localparam int BIT_IRQEN  = 6;
  localparam int BIT_GRPEN  = 7;
  localparam int SEL_LSB    = 2;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_CAPT = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic     tick;
    logic     cntLoad;
    logic     capEdge;
    tmrMode_e mode;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 8,
  parameter bit HAS_EXT_CLK = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CNT_W-1:0]    regWrData,
  output logic [CNT_W-1:0]    regRdData,
  input  logic                grpStart,
  input  logic                grpStop,
  input  logic                extClk,
  input  logic                capTrig,
  input  logic [CNT_W-1:0]    cntQ,
  input  logic [CNT_W-1:0]    capQ,
  input  logic                evOvf,
  input  logic                evMatch,
  input  logic                evCap,
  output tmrStrobe_t          stb,
  output logic [CNT_W-1:0]    reloadVal,
  output logic [CNT_W-1:0]    cmpVal,
  output logic                flagQ,
  output logic                irq,
  output logic                waveEn
);
  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int PRE_W = NUM_SRC - 2;

  logic [CTRL_W-1:0] ctrlReg;
  logic [PRE_W-1:0]  preQ;
  logic [2:0]        extSync;
  logic [2:0]        trgSync;
  logic [NUM_SRC-1:0] srcTick;
  logic              extRise;
  logic              trgRise;
  logic [SEL_W-1:0]  clkSel;
  tmrMode_e          mode;
  logic              wrCtrl;
  logic              anyEvent;

  assign clkSel = ctrlReg[SEL_LSB +: SEL_W];
  assign mode   = tmrMode_e'(ctrlReg[1:0]);
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else       preQ <= preQ + 1'b1;
  end

  // two-flop synchronisers plus an edge-history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      trgSync <= '0;
    end else begin
      extSync <= {extSync[1:0], extClk};
      trgSync <= {trgSync[1:0], capTrig};
    end
  end
  assign extRise = extSync[1] & ~extSync[2];
  assign trgRise = trgSync[1] & ~trgSync[2];

  // tick sources: divided taps, then the optional external clock
  for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign srcTick[k] = 1'b1;
    end else begin : g_div
      assign srcTick[k] = &preQ[k-1:0];
    end
  end
  if (HAS_EXT_CLK) begin : g_ext
    assign srcTick[NUM_SRC-1] = extRise;
  end else begin : g_noext
    assign srcTick[NUM_SRC-1] = 1'b0;
  end

  // control register with group start/stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= regWrData[CTRL_W-1:0];
    end else if (ctrlReg[BIT_GRPEN]) begin
      if (grpStart)     ctrlReg[BIT_RUN] <= 1'b1;
      else if (grpStop) ctrlReg[BIT_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
      cmpVal    <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_RELOAD) reloadVal <= regWrData;
      if (regAddr == ADDR_CMP)    cmpVal    <= regWrData;
    end
  end

  assign anyEvent = evOvf | evMatch | evCap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                                  flagQ <= 1'b0;
    else if (anyEvent)                                          flagQ <= 1'b1;
    else if (regWrEn && regAddr == ADDR_STAT && regWrData[0])   flagQ <= 1'b0;
  end

  assign stb.tick    = ctrlReg[BIT_RUN] & srcTick[clkSel];
  assign stb.cntLoad = regWrEn && (regAddr == ADDR_COUNT);
  assign stb.capEdge = trgRise;
  assign stb.mode    = mode;

  assign irq    = flagQ & ctrlReg[BIT_IRQEN];
  assign waveEn = (mode == MODE_CMP) || (mode == MODE_PWM);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:   regRdData[CTRL_W-1:0] = ctrlReg;
      ADDR_RELOAD: regRdData = reloadVal;
      ADDR_CMP:    regRdData = cmpVal;
      ADDR_COUNT:  regRdData = cntQ;
      ADDR_CAPT:   regRdData = capQ;
      ADDR_STAT:   regRdData[0] = flagQ;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] capQ,
  output logic             evOvf,
  output logic             evMatch,
  output logic             evCap,
  output logic             waveOut
);
  logic [CNT_W-1:0] wrapAt;
  logic [CNT_W-1:0] cntNext;
  logic             atWrap;
  logic             togQ;
  logic             isPwm;

  assign isPwm   = (stb.mode == MODE_PWM);
  assign wrapAt  = isPwm ? (reloadVal - 1'b1) : '1;
  assign atWrap  = (cntQ == wrapAt);
  assign cntNext = atWrap ? (isPwm ? '0 : reloadVal) : (cntQ + 1'b1);

  assign evOvf   = stb.tick & atWrap;
  assign evMatch = stb.tick & (stb.mode == MODE_CMP) & (cntQ == cmpVal);
  assign evCap   = stb.capEdge & (stb.mode == MODE_CAPT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.cntLoad) cntQ <= loadVal;
    else if (stb.tick)    cntQ <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      capQ <= '0;
    else if (evCap) capQ <= cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        togQ <= 1'b0;
    else if (evMatch) togQ <= ~togQ;
  end

  always_comb begin
    case (stb.mode)
      MODE_CMP: waveOut = togQ;
      MODE_PWM: waveOut = (cntQ < cmpVal);
      default:  waveOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 8,
  parameter bit HAS_EXT_CLK = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRdData,
  input  logic               grpStart,
  input  logic               grpStop,
  input  logic               extClk,
  input  logic               capTrig,
  output logic               waveOut,
  output logic               waveEn,
  output logic               irq
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] capQ;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cmpVal;
  logic             evOvf;
  logic             evMatch;
  logic             evCap;
  logic             flagQ;

  tmr_ctrl #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .HAS_EXT_CLK(HAS_EXT_CLK)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .grpStart(grpStart),
    .grpStop(grpStop), .extClk(extClk), .capTrig(capTrig), .cntQ(cntQ),
    .capQ(capQ), .evOvf(evOvf), .evMatch(evMatch), .evCap(evCap), .stb(stb),
    .reloadVal(reloadVal), .cmpVal(cmpVal), .flagQ(flagQ), .irq(irq),
    .waveEn(waveEn)
  );

  tmr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(regWrData),
    .reloadVal(reloadVal), .cmpVal(cmpVal), .cntQ(cntQ), .capQ(capQ),
    .evOvf(evOvf), .evMatch(evMatch), .evCap(evCap), .waveOut(waveOut)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input tmrStrobe_t       stb,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] capQ,
  input logic             evOvf,
  input logic             evMatch,
  input logic             evCap,
  input logic             flagQ,
  input logic             waveEn,
  input logic             waveOut
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.cntLoad && !evOvf) |=> (cntQ == $past(cntQ) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !stb.cntLoad) |=> $stable(cntQ));

  // R6
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    evCap |=> (capQ == $past(cntQ)));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evOvf || evMatch || evCap) |=> flagQ);

  // R7
  wave_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !waveEn |-> !waveOut);

  // R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evCap |=> $stable(capQ));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .cntQ(cntQ), .capQ(capQ),
  .evOvf(evOvf), .evMatch(evMatch), .evCap(evCap), .flagQ(flagQ),
  .waveEn(waveEn), .waveOut(waveOut)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        grpStart = 1'b0;
  logic        grpStop = 1'b0;
  logic        extClk = 1'b0;
  logic        capTrig = 1'b0;
  logic        waveOut, waveEn, irq;

  always #4 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .grpStart(grpStart),
    .grpStop(grpStop), .extClk(extClk), .capTrig(capTrig),
    .waveOut(waveOut), .waveEn(waveEn), .irq(irq)
  );

  int vecCnt = 0;
  int errCnt = 0;
  string curReq = "R1";
  bit started = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int mPre, mCnt, mCap, mReload, mCmp, mCtrl;
  bit mFlag, mTog;
  bit [2:0] mE, mT;

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mCap = 0; mReload = 0; mCmp = 0; mCtrl = 0;
      mFlag = 0; mTog = 0; mE = 0; mT = 0;
      started = 1'b1;
    end else begin
      int sel, mode, nxt;
      bit tk, ovf, match, capE, extR, trgR, wr;
      sel  = (mCtrl >> 2) & 7;
      mode = mCtrl & 3;
      extR = mE[1] & ~mE[2];
      trgR = mT[1] & ~mT[2];
      wr   = regWrEn;
      if (sel < 7) tk = mCtrl[5] && ((mPre % (1 << sel)) == (1 << sel) - 1);
      else         tk = mCtrl[5] && extR;
      ovf = 0; match = 0; capE = 0; nxt = mCnt;
      if (tk) begin
        if (mode == 2) begin
          if (mCnt == ((mReload + 65535) % 65536)) begin nxt = 0; ovf = 1; end
          else nxt = mCnt + 1;
        end else begin
          if (mCnt == 65535) begin nxt = mReload; ovf = 1; end
          else nxt = mCnt + 1;
        end
        if (mode == 1 && mCnt == mCmp) match = 1;
      end
      if (mode == 3 && trgR) begin mCap = mCnt; capE = 1; end
      if (match) mTog = ~mTog;
      if (wr && regAddr == 3) nxt = regWrData;
      if (ovf || match || capE) mFlag = 1;
      else if (wr && regAddr == 5 && regWrData[0]) mFlag = 0;
      if (wr && regAddr == 0) mCtrl = regWrData & 255;
      else if (mCtrl[7] && grpStart) mCtrl = mCtrl | 32;
      else if (mCtrl[7] && grpStop)  mCtrl = mCtrl & ~32;
      if (wr && regAddr == 1) mReload = regWrData;
      if (wr && regAddr == 2) mCmp = regWrData;
      mCnt = nxt % 65536;
      mPre = (mPre + 1) % 64;
      mE = {mE[1:0], extClk};
      mT = {mT[1:0], capTrig};
    end
  end

  function automatic int modelRead(int a);
    case (a)
      0: return mCtrl;
      1: return mReload;
      2: return mCmp;
      3: return mCnt;
      4: return mCap;
      5: return int'(mFlag);
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      int md;
      bit expWave, expEn;
      md = mCtrl & 3;
      expEn = (md == 1) || (md == 2);
      expWave = (md == 1) ? mTog : (md == 2) ? (mCnt < mCmp) : 1'b0;
      check("regRdData", regRdData, modelRead(regAddr));
      check("waveOut", waveOut, expWave);
      check("waveEn", waveEn, expEn);
      check("irq", irq, mFlag & mCtrl[6]);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d, int mon);
    regWrEn = 1'b1; regAddr = a[2:0]; regWrData = d[15:0];
    step(1);
    regWrEn = 1'b0; regAddr = mon[2:0];
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    // R1 and R11: reset values across the map, including unused addresses
    curReq = "R1";
    for (int a = 0; a < 8; a++) begin regAddr = a[2:0]; step(1); end

    // R2 / R9 / R10: wrap with reload, flag, irq
    curReq = "R2";
    wr(1, 16'hFFF0, 3);
    wr(3, 16'hFFFA, 3);
    wr(0, 16'h0060, 3);           // mode 0, sel 0, run, irq enable
    step(12);
    curReq = "R9";
    regAddr = 5; step(2);
    wr(5, 1, 5);                   // clear flag
    step(2);
    // clear in the cycle an overflow arrives: set wins
    wr(3, 16'hFFFE, 5);
    step(1);
    wr(5, 1, 5);
    step(3);
    wr(5, 1, 5);
    step(2);
    curReq = "R10";
    regAddr = 3;
    wr(3, 16'h1234, 3);
    step(3);
    wr(3, 16'h0100, 3);
    step(2);

    // R3: divided clocks
    curReq = "R3";
    wr(0, 16'h0028, 3);           // sel 2, run
    step(40);
    wr(0, 16'h0038, 3);           // sel 6, run
    step(200);
    // R3: external clock through the synchroniser
    wr(0, 16'h003C, 3);           // sel 7, run
    for (int i = 0; i < 10; i++) begin
      extClk = 1'b1; step(3);
      extClk = 1'b0; step(4);
    end

    // R4 / R7: compare toggling
    curReq = "R4";
    wr(2, 5, 3);
    wr(3, 0, 3);
    wr(0, 16'h0021, 3);           // mode 1, sel 0, run
    step(12);
    wr(3, 0, 3);
    step(10);
    curReq = "R7";
    wr(0, 16'h0020, 3);           // back to mode 0
    step(5);

    // R5: PWM with several duties
    curReq = "R5";
    wr(1, 10, 3);
    wr(3, 0, 3);
    wr(2, 3, 3);
    wr(0, 16'h0062, 3);           // mode 2, run, irq enable
    step(25);
    wr(2, 0, 3);  step(22);
    wr(2, 12, 3); step(22);
    wr(2, 10, 3); step(22);
    wr(2, 9, 3);  step(22);

    // R6: capture
    curReq = "R6";
    wr(5, 1, 4);
    wr(0, 16'h0023, 4);           // mode 3, run
    step(5);
    capTrig = 1'b1; step(3); capTrig = 1'b0; step(6);
    regAddr = 5; step(2);
    capTrig = 1'b1; step(1); capTrig = 1'b0; step(6);
    regAddr = 4;
    // trigger in a non-capture mode has no effect
    wr(0, 16'h0020, 4);
    capTrig = 1'b1; step(4); capTrig = 1'b0; step(6);

    // R8: group start / stop
    curReq = "R8";
    wr(0, 16'h0080, 3);           // armed, stopped
    step(4);
    grpStart = 1'b1; step(1); grpStart = 1'b0; step(6);
    grpStop = 1'b1; step(1); grpStop = 1'b0; step(6);
    grpStart = 1'b1; grpStop = 1'b1; step(1);
    grpStart = 1'b0; grpStop = 1'b0; step(5);
    regAddr = 0; step(1);
    wr(0, 16'h0000, 3);           // not armed
    grpStart = 1'b1; step(1); grpStart = 1'b0; step(5);
    wr(0, 16'h00A0, 3);
    grpStop = 1'b1; step(1); grpStop = 1'b0; step(5);

    // R11: read back every register
    curReq = "R11";
    for (int a = 0; a < 8; a++) begin regAddr = a[2:0]; step(1); end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule